// File: doc/BRIEF.md
# Coupling-Aware Odd-Line Inversion Flit Codec

This block sits at the link port of a network interface and lowers dynamic power on a point-to-point flit link. Power on such a link comes from lines rising (self switching) and from neighbouring lines switching against each other (coupling). For every body or tail flit, the encoder weighs two candidate words against the word last sent on the link. One candidate is the data as is. The other has every odd-indexed data line flipped. The encoder sends the cheaper candidate. A dedicated flag line tells the far end which choice was made. Header flits go out untouched, so routers can read them as they are.

The encoder is combinational from its flit input to its link output. Its only state is a history register holding the last accepted link word. Handshake signals pass straight through, so the codec adds no latency and no buffering. The decoder half is purely combinational. It restores the data word from a received link word, its flag line and a header marker. In a system the decoder sits at the destination interface, and the routers in between never see the encoding.

Top module: `flit_codec`

## Requirements
- R1: The link is LINK_W lines wide. Lines 0 to LINK_W-2 carry data and line LINK_W-1 is the flag. When the flag is 1 on a non-header beat, the data lines at odd indices (1, 3, 5, ...) carry the inverse of the input data bits and the even-indexed lines carry them unchanged. When the flag is 0, all data lines carry the input unchanged.
- R2: A header beat (in_head_i = 1) is sent with the flag at 0 and the data lines equal to in_data_i, whatever the history holds.
- R3: The cost of a candidate word against the history word has three parts, all counted over all LINK_W lines including the flag. It counts 1 for each line going 0 to 1. It counts 1 for each adjacent line pair in which exactly one line toggles. It counts 2 for each adjacent pair in which both lines toggle in opposite directions. The cost of the word sent never exceeds the cost of the plain candidate {0, data}.
- R4: For body and tail beats, the flag is 1 exactly when the cost of the inverted candidate (flag 1) is strictly lower than the cost of the plain candidate (flag 0). A tie sends the plain candidate.
- R5: The history register resets to zero. After an accepted header beat it becomes zero. After an accepted body or tail beat it becomes the link word sent. It holds its value in every cycle without an accepted beat, so a stalled flit keeps the same encoding.
- R6: out_valid_o equals in_valid_i, in_ready_o equals out_ready_i, and out_head_o and out_tail_o equal in_head_i and in_tail_i, all in the same cycle.
- R7: rx_data_o equals the received data lines XOR the odd-index mask when rx_head_i = 0 and the received flag is 1. Otherwise, including every header beat whatever its flag line shows, rx_data_o equals the received data lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input flit valid |
| in_ready_o | output | 1 | Input flit accepted when high with valid |
| in_data_i | input | LINK_W-1 | Input flit data |
| in_head_i | input | 1 | Input flit is a packet header |
| in_tail_i | input | 1 | Input flit ends the packet |
| out_valid_o | output | 1 | Link beat valid |
| out_ready_i | input | 1 | Link accepts the beat |
| out_link_o | output | LINK_W | Encoded link word, flag in the top bit |
| out_head_o | output | 1 | Link beat is a header |
| out_tail_o | output | 1 | Link beat ends the packet |
| rx_link_i | input | LINK_W | Received link word for decoding |
| rx_head_i | input | 1 | Received beat is a header |
| rx_data_o | output | LINK_W-1 | Decoded flit data |

## Verification
Two functions meet at every clock edge: the encoding decision for the beat on the wires, and the history update left by the beat accepted just before. A wrong update order shows up only in the following decision. The bench provokes this by loading many different history words through accepted body beats, then holding the output stalled while it sweeps all data values. Each stalled output is judged against a bench-side cost model using the history the bench expects, and the same beat is decoded in that cycle through a loopback to prove recovery.

// File: rtl/flit_codec_pkg.sv
package flit_codec_pkg;
  // coupling weight of one adjacent line pair between two consecutive words
  function automatic logic [1:0] pair_weight(input logic p_lo, input logic p_hi,
                                             input logic c_lo, input logic c_hi);
    logic t_lo, t_hi;
    t_lo = p_lo ^ c_lo;
    t_hi = p_hi ^ c_hi;
    if (t_lo != t_hi) return 2'd1;
    if (t_lo && (c_lo != c_hi)) return 2'd2;
    return 2'd0;
  endfunction
endpackage

// File: rtl/codec_cost.sv
module codec_cost #(
  parameter int W  = 8,
  parameter int CW = $clog2(3 * W) + 1
) (
  input  logic [W-1:0]  prev_i,
  input  logic [W-1:0]  cand_i,
  output logic [CW-1:0] cost_o
);
  import flit_codec_pkg::*;

  logic [W-1:0] rise;
  logic [1:0]   pw [W-1];

  for (genvar gi = 0; gi < W; gi++) begin : g_rise
    assign rise[gi] = ~prev_i[gi] & cand_i[gi];
  end

  for (genvar gp = 0; gp < W - 1; gp++) begin : g_pair
    assign pw[gp] = pair_weight(prev_i[gp], prev_i[gp+1], cand_i[gp], cand_i[gp+1]);
  end

  always_comb begin
    cost_o = '0;
    for (int j = 0; j < W; j++)     cost_o = cost_o + CW'(rise[j]);
    for (int j = 0; j < W - 1; j++) cost_o = cost_o + CW'(pw[j]);
  end
endmodule

// File: rtl/codec_enc.sv
module codec_enc #(
  parameter int LINK_W = 8,
  localparam int DW = LINK_W - 1
) (
  input  logic [DW-1:0]     data_i,
  input  logic              head_i,
  input  logic [LINK_W-1:0] hist_i,
  output logic [LINK_W-1:0] link_o
);
  localparam int CW = $clog2(3 * LINK_W) + 1;

  logic [DW-1:0]     odd_mask;
  logic [LINK_W-1:0] cand_plain, cand_inv;
  logic [CW-1:0]     cost_plain, cost_inv;

  for (genvar gi = 0; gi < DW; gi++) begin : g_mask
    assign odd_mask[gi] = (gi % 2 == 1);
  end

  assign cand_plain = {1'b0, data_i};
  assign cand_inv   = {1'b1, data_i ^ odd_mask};

  codec_cost #(.W(LINK_W), .CW(CW)) i_cost_plain (
    .prev_i(hist_i), .cand_i(cand_plain), .cost_o(cost_plain)
  );
  codec_cost #(.W(LINK_W), .CW(CW)) i_cost_inv (
    .prev_i(hist_i), .cand_i(cand_inv), .cost_o(cost_inv)
  );

  always_comb begin
    if (head_i)                     link_o = cand_plain;
    else if (cost_inv < cost_plain) link_o = cand_inv;
    else                            link_o = cand_plain;
  end
endmodule

// File: rtl/codec_dec.sv
module codec_dec #(
  parameter int LINK_W = 8,
  localparam int DW = LINK_W - 1
) (
  input  logic [LINK_W-1:0] link_i,
  input  logic              head_i,
  output logic [DW-1:0]     data_o
);
  logic [DW-1:0] odd_mask;

  for (genvar gi = 0; gi < DW; gi++) begin : g_mask
    assign odd_mask[gi] = (gi % 2 == 1);
  end

  assign data_o = (!head_i && link_i[DW]) ? (link_i[DW-1:0] ^ odd_mask)
                                          : link_i[DW-1:0];
endmodule

// File: rtl/flit_codec.sv
module flit_codec #(
  parameter int LINK_W = 8,
  localparam int DW = LINK_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DW-1:0]     in_data_i,
  input  logic              in_head_i,
  input  logic              in_tail_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [LINK_W-1:0] out_link_o,
  output logic              out_head_o,
  output logic              out_tail_o,
  input  logic [LINK_W-1:0] rx_link_i,
  input  logic              rx_head_i,
  output logic [DW-1:0]     rx_data_o
);
  logic [LINK_W-1:0] hist_q;
  logic              fire;

  assign out_valid_o = in_valid_i;
  assign in_ready_o  = out_ready_i;
  assign out_head_o  = in_head_i;
  assign out_tail_o  = in_tail_i;
  assign fire        = in_valid_i & out_ready_i;

  codec_enc #(.LINK_W(LINK_W)) i_enc (
    .data_i(in_data_i), .head_i(in_head_i), .hist_i(hist_q), .link_o(out_link_o)
  );

  // a header restarts the history so the first body flit compares against zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hist_q <= '0;
    else if (fire)      hist_q <= in_head_i ? '0 : out_link_o;
  end

  codec_dec #(.LINK_W(LINK_W)) i_dec (
    .link_i(rx_link_i), .head_i(rx_head_i), .data_o(rx_data_o)
  );
endmodule

// File: rtl/flit_codec_chk.sv
module flit_codec_chk #(
  parameter int LINK_W = 8,
  localparam int DW = LINK_W - 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [DW-1:0]     in_data_i,
  input logic              in_head_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [LINK_W-1:0] out_link_o,
  input logic              out_head_o,
  input logic [LINK_W-1:0] hist_q
);
  logic [DW-1:0] odd_mask;
  logic          fire;

  for (genvar gi = 0; gi < DW; gi++) begin : g_mask
    assign odd_mask[gi] = (gi % 2 == 1);
  end
  assign fire = out_valid_o && out_ready_i;

  AST_HEAD_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && in_head_i) |-> (out_link_o == {1'b0, in_data_i})); // R2

  AST_BODY_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !in_head_i) |->
      ((out_link_o[DW-1:0] ^ in_data_i) == (out_link_o[DW] ? odd_mask : '0))); // R1

  AST_HANDSHAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o == out_ready_i) && (out_valid_o == in_valid_i)); // R6

  AST_HIST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && out_head_o) |=> (hist_q == '0)); // R5

  AST_HIST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !out_head_o) |=> (hist_q == $past(out_link_o))); // R5

  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(hist_q)); // R5
endmodule

bind flit_codec flit_codec_chk #(.LINK_W(LINK_W)) i_chk (.*);

// File: tb/test_flit_codec.sv
module test_flit_codec;
  localparam int LINK_W = 8;
  localparam int DW = LINK_W - 1;
  localparam logic [DW-1:0] ODD = 7'h2A;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0, in_head = 1'b0, in_tail = 1'b0, out_ready = 1'b0;
  logic [DW-1:0]     in_data = '0;
  logic              in_ready, out_valid, out_head, out_tail;
  logic [LINK_W-1:0] out_link;
  logic              use_loop = 1'b1;
  logic [LINK_W-1:0] rx_link_drv = '0;
  logic              rx_head_drv = 1'b0;
  logic [LINK_W-1:0] rx_link;
  logic              rx_head;
  logic [DW-1:0]     rx_data;

  int checks = 0, errors = 0;
  logic [LINK_W-1:0] model_hist = '0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  assign rx_link = use_loop ? out_link : rx_link_drv;
  assign rx_head = use_loop ? out_head : rx_head_drv;

  flit_codec #(.LINK_W(LINK_W)) i_flit_codec (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_head_i(in_head), .in_tail_i(in_tail),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_link_o(out_link),
    .out_head_o(out_head), .out_tail_o(out_tail),
    .rx_link_i(rx_link), .rx_head_i(rx_head), .rx_data_o(rx_data)
  );

  function automatic int cost(input logic [LINK_W-1:0] p, input logic [LINK_W-1:0] c);
    int s = 0;
    for (int j = 0; j < LINK_W; j++) if (!p[j] && c[j]) s++;
    for (int j = 0; j < LINK_W - 1; j++) begin
      logic ta, tb;
      ta = p[j] ^ c[j];
      tb = p[j+1] ^ c[j+1];
      if (ta != tb) s += 1;
      else if (ta && tb && (c[j] != c[j+1])) s += 2;
    end
    return s;
  endfunction

  function automatic logic [LINK_W-1:0] enc_model(input logic [LINK_W-1:0] p,
                                                   input logic [DW-1:0] d);
    logic [LINK_W-1:0] pl, iv;
    pl = {1'b0, d};
    iv = {1'b1, d ^ ODD};
    return (cost(p, iv) < cost(p, pl)) ? iv : pl;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present one beat; sample mid-cycle; optionally accept at the next edge
  task automatic beat(input logic hd, input logic [DW-1:0] d, input logic tl, input logic rdy);
    logic [LINK_W-1:0] exp;
    @(negedge clk);
    in_valid = 1'b1; in_head = hd; in_data = d; in_tail = tl; out_ready = rdy;
    #2;
    exp = hd ? {1'b0, d} : enc_model(model_hist, d);
    chk(hd ? "R2 header word" : "R4 encoded word", 32'(out_link), 32'(exp));
    chk("R7 loopback data", 32'(rx_data), 32'(d));
    chk("R6 handshake/markers", {28'd0, in_ready, out_valid, out_head, out_tail},
        {28'd0, rdy, 1'b1, hd, tl});
    if (!hd) begin
      checks++;
      if (cost(model_hist, out_link) > cost(model_hist, {1'b0, d})) begin
        errors++;
        $display("FAIL R3 cost actual=%0d expected<=%0d",
                 cost(model_hist, out_link), cost(model_hist, {1'b0, d}));
      end
    end
    if (rdy) begin
      @(posedge clk);
      model_hist = hd ? '0 : exp;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R5 reset state: history zero, so encoding is against all-zero word
    beat(1'b0, 7'h7F, 1'b0, 1'b0);
    chk("R5 reset history", 32'(out_link), 32'(enc_model('0, 7'h7F)));
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    chk("R6 valid follows", 32'(out_valid), 32'd0);

    // near-exhaustive: 16 history words, all data values while stalled
    for (int k = 0; k < 16; k++) begin
      beat(1'b1, 7'(k * 5), 1'b0, 1'b1);
      beat(1'b0, 7'(k * 8 + 3), 1'b0, 1'b1);
      for (int d = 0; d < 128; d++) beat(1'b0, 7'(d), 1'b0, 1'b0);
      beat(1'b0, 7'(k * 3 + 1), 1'b1, 1'b1);
    end

    // R5 header clears history even after a non-zero body word
    beat(1'b1, 7'h55, 1'b0, 1'b1);
    beat(1'b0, 7'h7F, 1'b0, 1'b1);
    beat(1'b1, 7'h2A, 1'b0, 1'b1);
    chk("R5 header clears history", 32'(model_hist), 32'd0);
    beat(1'b0, 7'h7F, 1'b1, 1'b1);

    // random packets with random backpressure, decoded in loopback
    for (int p = 0; p < 400; p++) begin
      int len;
      len = 1 + int'($urandom % 5);
      for (int b = 0; b < len; b++) begin
        logic [DW-1:0] d;
        logic r;
        d = 7'($urandom);
        do begin
          r = ($urandom % 4) != 0;
          beat(b == 0, d, b == len - 1, r);
        end while (!r);
      end
    end

    // R7 decoder with direct drive
    @(negedge clk);
    in_valid = 1'b0;
    use_loop = 1'b0;
    rx_link_drv = 8'hFF; rx_head_drv = 1'b1;
    #2 chk("R7 header raw despite flag", 32'(rx_data), 32'h7F);
    rx_head_drv = 1'b0;
    #2 chk("R7 flag restores odd bits", 32'(rx_data), 32'h55);
    rx_link_drv = 8'h6B;
    #2 chk("R7 flag clear passes raw", 32'(rx_data), 32'h6B);
    rx_link_drv = 8'h80;
    #2 chk("R1 flag only inverts odd", 32'(rx_data), 32'(ODD));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule